// File: doc/BRIEF.md
# Tag-only cache hit/miss profiler

This block models the tag side of a set-associative cache that holds no data. A stream of address references goes in, one per clock at most. For each reference the block decides whether the referenced memory block would already be resident, updates its least-recently-used ordering, and pulses an event one cycle later. Three running 64-bit totals (hits, misses, evictions) are kept alongside the pulses, so a trace can be profiled against a chosen cache geometry without building the cache itself.

The geometry is fixed when the block is built: the number of set-index bits, block-offset bits and ways per set are parameters. The default is 5 set bits, 5 offset bits and one way, which gives a 1 KB direct-mapped cache of 32-byte blocks. The reference input is a plain valid strobe with no back-pressure: the block accepts a reference in every cycle that `req_valid` is high, and it never stalls.

Top module: `cprof_top`

## Requirements
- R1: After a synchronous reset (rst high at a rising edge), all three totals read zero, no event is pulsed, and every line is empty, so the first reference to any address is a miss without eviction.
- R2: The lowest OFS_BITS address bits play no part in lookup: two addresses that differ only in those bits hit the same line.
- R3: The set index is req_addr[OFS_BITS+SET_BITS-1:OFS_BITS] and the tag is every bit above it; a different tag in the same set is a different block, and references to different sets never disturb each other.
- R4: A reference presented with req_valid at a rising edge has its result on ev_hit/ev_miss/ev_evict from that edge until the next one; exactly one of ev_hit and ev_miss is high for a reference, and all three are low in a cycle that follows no reference.
- R5: A miss into a set that still has an empty line fills an empty line and pulses ev_miss without ev_evict, so a set of WAYS ways takes WAYS distinct cold blocks before any eviction.
- R6: A miss into a full set replaces the least-recently-used line of that set and pulses ev_evict together with ev_miss.
- R7: A hit makes the hit line the most recently used one of its set, so it is not the next victim.
- R8: cnt_hits, cnt_misses and cnt_evictions each rise by one in the same cycle as the matching event pulse, and cnt_evictions never exceeds cnt_misses.
- R9: With WAYS = 1 the block acts as a direct-mapped cache: two blocks alternating in one set miss and evict on every reference.
- R10: References on consecutive cycles are each classified against the state left by the one before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A reference is present this cycle |
| req_addr | input | ADDR_W (64) | Byte address of the reference |
| ev_hit | output | 1 | Previous-cycle reference hit |
| ev_miss | output | 1 | Previous-cycle reference missed |
| ev_evict | output | 1 | Previous-cycle miss displaced a valid line |
| cnt_hits | output | CNT_W (64) | Running total of hits |
| cnt_misses | output | CNT_W (64) | Running total of misses |
| cnt_evictions | output | CNT_W (64) | Running total of evictions |

## Verification
The assertions take for granted that req_addr carries known bits whenever req_valid is high and that reset is held for at least one edge before the first reference; with those, every reference must produce exactly one classification and an eviction can only ride on a miss. The stimulus drives req_addr and req_valid only on falling edges and holds the address steady through the sampling edge, and it applies reset before any reference. Expected events come from a hand-worked trace of tags per set, including the recency order of a four-way set through fills, promoting hits and successive victims.

// File: rtl/cprof_pkg.sv
package cprof_pkg;

  typedef struct packed {
    logic hit;
    logic miss;
    logic evict;
  } cprof_event_t;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/cprof_lookup.sv
module cprof_lookup
  import cprof_pkg::*;
#(
  parameter int WAYS  = 1,
  parameter int TAG_W = 54,
  parameter int AGE_W = 1,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0]             line_vld,
  input  logic [WAYS-1:0][TAG_W-1:0]  line_tag,
  input  logic [WAYS-1:0][AGE_W-1:0]  line_age,
  input  logic [TAG_W-1:0]            req_tag,
  output logic                        hit,
  output logic                        evict,
  output logic [WAY_W-1:0]            sel_way,
  output logic [AGE_W-1:0]            ref_age
);

  logic             have_free;
  logic [WAY_W-1:0] hit_way, free_way, old_way;
  logic [AGE_W-1:0] old_age;

  always_comb begin
    hit = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (line_vld[w] && line_tag[w] == req_tag) begin
        hit = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
    // lowest-numbered empty way wins
    have_free = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!line_vld[w]) begin
        have_free = 1'b1;
        free_way = WAY_W'(w);
      end
    end
    // oldest line of the set is the victim
    old_way = '0;
    old_age = line_age[0];
    for (int w = 1; w < WAYS; w++) begin
      if (line_age[w] > old_age) begin
        old_age = line_age[w];
        old_way = WAY_W'(w);
      end
    end
  end

  assign evict   = !hit && !have_free;
  assign sel_way = hit ? hit_way : (have_free ? free_way : old_way);
  // ages below ref_age move up by one; an empty-line fill ages every line
  assign ref_age = hit ? line_age[hit_way] :
                   (have_free ? AGE_W'(WAYS) : old_age);

endmodule

// File: rtl/cprof_counter.sv
module cprof_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] value
);

  always_ff @(posedge clk) begin
    if (rst) value <= '0;
    else if (inc) value <= value + 1'b1;
  end

endmodule

// File: rtl/cprof_top.sv
module cprof_top
  import cprof_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int SET_BITS = 5,
  parameter int OFS_BITS = 5,
  parameter int WAYS     = 1,
  parameter int CNT_W    = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              ev_hit,
  output logic              ev_miss,
  output logic              ev_evict,
  output logic [CNT_W-1:0]  cnt_hits,
  output logic [CNT_W-1:0]  cnt_misses,
  output logic [CNT_W-1:0]  cnt_evictions
);

  localparam int SETS  = 1 << SET_BITS;
  localparam int TAG_W = ADDR_W - SET_BITS - OFS_BITS;
  localparam int AGE_W = $clog2(WAYS + 1);
  localparam int WAY_W = idx_bits(WAYS);

  logic [WAYS-1:0]            vld  [SETS];
  logic [WAYS-1:0][TAG_W-1:0] tags [SETS];
  logic [WAYS-1:0][AGE_W-1:0] ages [SETS];

  logic [SET_BITS-1:0] set_idx;
  logic [TAG_W-1:0]    req_tag;
  logic                unused_ofs;

  assign set_idx    = req_addr[OFS_BITS +: SET_BITS];
  assign req_tag    = req_addr[ADDR_W-1 -: TAG_W];
  assign unused_ofs = ^req_addr[OFS_BITS-1:0];

  logic             lk_hit, lk_evict;
  logic [WAY_W-1:0] lk_way;
  logic [AGE_W-1:0] lk_age;

  cprof_lookup #(
    .WAYS(WAYS), .TAG_W(TAG_W), .AGE_W(AGE_W), .WAY_W(WAY_W)
  ) lookup_i (
    .line_vld (vld[set_idx]),
    .line_tag (tags[set_idx]),
    .line_age (ages[set_idx]),
    .req_tag  (req_tag),
    .hit      (lk_hit),
    .evict    (lk_evict),
    .sel_way  (lk_way),
    .ref_age  (lk_age)
  );

  cprof_event_t now_ev, ev_q;
  assign now_ev.hit   = req_valid && lk_hit;
  assign now_ev.miss  = req_valid && !lk_hit;
  assign now_ev.evict = req_valid && lk_evict;

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_q <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld[s]  <= '0;
        ages[s] <= '0;
      end
    end else begin
      ev_q <= now_ev;
      if (req_valid) begin
        vld[set_idx][lk_way]  <= 1'b1;
        tags[set_idx][lk_way] <= req_tag;
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == lk_way)
            ages[set_idx][w] <= '0;
          else if (vld[set_idx][w] && ages[set_idx][w] < lk_age)
            ages[set_idx][w] <= ages[set_idx][w] + 1'b1;
        end
      end
    end
  end

  assign ev_hit   = ev_q.hit;
  assign ev_miss  = ev_q.miss;
  assign ev_evict = ev_q.evict;

  logic [2:0]            incs;
  logic [2:0][CNT_W-1:0] totals;
  assign incs = {now_ev.evict, now_ev.miss, now_ev.hit};

  for (genvar g = 0; g < 3; g++) begin : g_cnt
    cprof_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk(clk), .rst(rst), .inc(incs[g]), .value(totals[g])
    );
  end

  assign cnt_hits      = totals[0];
  assign cnt_misses    = totals[1];
  assign cnt_evictions = totals[2];

  // R4: one classification per reference, never both
  assert_one_class_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_hit, ev_miss}));
  // R4: an event only follows a reference, and every reference yields one
  assert_event_after_req_R4: assert property (@(posedge clk) disable iff (rst)
    (ev_hit || ev_miss) |-> $past(req_valid));
  assert_req_classified_R4: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (ev_hit || ev_miss));
  // R6: an eviction rides on a miss
  assert_evict_is_miss_R6: assert property (@(posedge clk) disable iff (rst)
    ev_evict |-> ev_miss);
  // R8: totals move with their event pulses
  assert_hit_count_R8: assert property (@(posedge clk) disable iff (rst)
    ev_hit |-> cnt_hits == $past(cnt_hits) + 1'b1);
  assert_miss_count_R8: assert property (@(posedge clk) disable iff (rst)
    !ev_miss |-> $stable(cnt_misses));
  assert_evict_bound_R8: assert property (@(posedge clk) disable iff (rst)
    cnt_evictions <= cnt_misses);

endmodule

// File: tb/cprof_top_tb_top.sv
module cprof_top_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // direct-mapped default: 5 set bits, 5 offset bits
  logic        dm_v = 1'b0;
  logic [63:0] dm_a = '0;
  logic        dm_h, dm_m, dm_e;
  logic [63:0] dm_ch, dm_cm, dm_ce;

  // 4-way: 2 set bits, 4 offset bits
  logic        w4_v = 1'b0;
  logic [63:0] w4_a = '0;
  logic        w4_h, w4_m, w4_e;
  logic [63:0] w4_ch, w4_cm, w4_ce;

  longint unsigned xd_h = 0, xd_m = 0, xd_e = 0;
  longint unsigned x4_h = 0, x4_m = 0, x4_e = 0;

  cprof_top dut_i (
    .clk(clk), .rst(rst), .req_valid(dm_v), .req_addr(dm_a),
    .ev_hit(dm_h), .ev_miss(dm_m), .ev_evict(dm_e),
    .cnt_hits(dm_ch), .cnt_misses(dm_cm), .cnt_evictions(dm_ce)
  );

  cprof_top #(.SET_BITS(2), .OFS_BITS(4), .WAYS(4)) dut_w4_i (
    .clk(clk), .rst(rst), .req_valid(w4_v), .req_addr(w4_a),
    .ev_hit(w4_h), .ev_miss(w4_m), .ev_evict(w4_e),
    .cnt_hits(w4_ch), .cnt_misses(w4_cm), .cnt_evictions(w4_ce)
  );

  function automatic logic [63:0] mk_dm(input longint unsigned tag, input int set, input int ofs);
    return {tag[53:0], 5'(set), 5'(ofs)};
  endfunction

  function automatic logic [63:0] mk_w4(input longint unsigned tag, input int set, input int ofs);
    return {tag[57:0], 2'(set), 4'(ofs)};
  endfunction

  task automatic check(input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_dm(input string req, input bit h, input bit m, input bit e);
    xd_h += h; xd_m += m; xd_e += e;
    check(req, "dm hit", dm_h, h);
    check(req, "dm miss", dm_m, m);
    check(req, "dm evict", dm_e, e);
    check("R8", "dm hits total", dm_ch, xd_h);
    check("R8", "dm misses total", dm_cm, xd_m);
    check("R8", "dm evictions total", dm_ce, xd_e);
  endtask

  task automatic ref_dm(input string req, input logic [63:0] a, input bit h, input bit m, input bit e);
    @(negedge clk); dm_v = 1'b1; dm_a = a;
    @(negedge clk); dm_v = 1'b0;
    check_dm(req, h, m, e);
  endtask

  task automatic ref_w4(input string req, input logic [63:0] a, input bit h, input bit m, input bit e);
    @(negedge clk); w4_v = 1'b1; w4_a = a;
    @(negedge clk); w4_v = 1'b0;
    x4_h += h; x4_m += m; x4_e += e;
    check(req, "w4 hit", w4_h, h);
    check(req, "w4 miss", w4_m, m);
    check(req, "w4 evict", w4_e, e);
    check("R8", "w4 hits total", w4_ch, x4_h);
    check("R8", "w4 misses total", w4_cm, x4_m);
    check("R8", "w4 evictions total", w4_ce, x4_e);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "dm events", {dm_h, dm_m, dm_e}, 0);
    check("R1", "dm totals", dm_ch | dm_cm | dm_ce, 0);
    check("R1", "w4 events", {w4_h, w4_m, w4_e}, 0);
    check("R1", "w4 totals", w4_ch | w4_cm | w4_ce, 0);
  endtask

  task automatic t_cold_and_offset();
    ref_dm("R1", mk_dm(5, 3, 0), 0, 1, 0);
    ref_dm("R2", mk_dm(5, 3, 31), 1, 0, 0);
    ref_dm("R2", mk_dm(5, 3, 17), 1, 0, 0);
  endtask

  task automatic t_fields();
    ref_dm("R3", mk_dm(6, 3, 0), 0, 1, 1);
    ref_dm("R3", mk_dm(5, 4, 0), 0, 1, 0);
    ref_dm("R3", mk_dm(6, 3, 9), 1, 0, 0);
    ref_dm("R3", mk_dm(5, 4, 2), 1, 0, 0);
  endtask

  task automatic t_direct_mapped();
    for (int i = 0; i < 4; i++)
      ref_dm("R9", mk_dm((i % 2 == 0) ? 40 : 41, 9, i), 0, 1, i > 0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    check("R4", "dm idle events", {dm_h, dm_m, dm_e}, 0);
    check("R4", "w4 idle events", {w4_h, w4_m, w4_e}, 0);
  endtask

  task automatic t_back_to_back();
    @(negedge clk); dm_v = 1'b1; dm_a = mk_dm(70, 7, 0);
    @(negedge clk); dm_a = mk_dm(71, 7, 0);
    check_dm("R10", 0, 1, 0);
    @(negedge clk); dm_a = mk_dm(71, 7, 4);
    check_dm("R10", 0, 1, 1);
    @(negedge clk); dm_a = mk_dm(70, 7, 0);
    check_dm("R10", 1, 0, 0);
    @(negedge clk); dm_v = 1'b0;
    check_dm("R10", 0, 1, 1);
  endtask

  task automatic t_lru();
    // four cold blocks fill set 1 without eviction
    for (int t = 10; t < 14; t++)
      ref_w4("R5", mk_w4(t, 1, 0), 0, 1, 0);
    ref_w4("R7", mk_w4(10, 1, 8), 1, 0, 0);   // 10 becomes newest; 11 oldest
    ref_w4("R6", mk_w4(14, 1, 0), 0, 1, 1);   // evicts 11
    ref_w4("R6", mk_w4(11, 1, 0), 0, 1, 1);   // evicts 12
    ref_w4("R7", mk_w4(10, 1, 3), 1, 0, 0);   // 10 survived; 13 oldest
    ref_w4("R6", mk_w4(12, 1, 0), 0, 1, 1);   // evicts 13
    ref_w4("R6", mk_w4(13, 1, 0), 0, 1, 1);   // evicts 14
    ref_w4("R3", mk_w4(10, 2, 0), 0, 1, 0);   // other set still empty
    ref_w4("R7", mk_w4(11, 1, 15), 1, 0, 0);
    ref_w4("R6", mk_w4(10, 1, 0), 1, 0, 0);   // 10 not yet displaced
  endtask

  initial begin
    t_reset();
    t_cold_and_offset();
    t_fields();
    t_direct_mapped();
    t_idle();
    t_back_to_back();
    t_lru();
    t_idle();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule